// File: doc/BRIEF.md
# SPI Master with Separate Write and Read Clock Dividers

This block is a single-channel SPI master driven by a small command port. The host programs it in three steps. It writes a set of mode flags. It writes two clock dividers, one used while bits are shifted out and one used while bits are shifted in. It writes a transfer shape: a chip-select pattern, a count of bits to send and a count of bits to receive. After that, every data word the host pushes starts one transfer.

A transfer first sends the requested number of bits, taken from the most significant end of the pushed word (or from the least significant end in LSB-first mode). It then receives the requested number of bits. These land right-aligned in a result register, which is announced by a one-cycle valid strobe. Because the read phase can run at a slower SCLK than the write phase, slow read-back paths are tolerated without slowing down writes.

A half-duplex mode turns the data line around for the read phase. An offline mode parks the bus. All commands are ignored while a transfer is in progress, and the busy output tells the host when the block will accept commands again.

Top module: `spi_split_master`

## Requirements
- R1: Commands are selected by `cmd_sel`. Code 0 loads the mode flags from `cmd_data[5:0]`: bit0 offline, bit1 chip-select polarity, bit2 clock polarity, bit3 clock phase, bit4 LSB-first, bit5 half-duplex. Code 1 loads the write divider from `cmd_data[7:0]` and the read divider from `cmd_data[23:16]`. Code 2 loads the chip-select pattern from `cmd_data[3:0]`, the write bit count from `cmd_data[13:8]` and the read bit count from `cmd_data[21:16]`. Code 3 pushes a data word and starts a transfer.
- R2: After reset, the block behaves as follows. `busy`, `sclk` and `rd_valid` are 0. `cs_o` is all ones. `mosi_oe` is 1. All flags are 0, the dividers are 24 (write) and 64 (read), and both bit counts are 0.
- R3: The chip select is active for W system cycles before the first bit and for W cycles after the last bit. Each SCLK half-period lasts W cycles during send bits and R cycles during receive bits, where W and R are the write and read dividers. `busy` is therefore high for exactly 2W + 2(wbits·W + rbits·R) cycles, starting the cycle after the data word is accepted.
- R4: Send bits leave on `mosi_o` starting at bit 31 of the word and going downwards. In LSB-first mode they start at bit 0 and go upwards.
- R5: Received bits are right-aligned in `rd_data`. With MSB-first order, the first received bit becomes bit rbits-1; with LSB-first order, it becomes bit 0. All bits above rbits-1 are 0. `rd_valid` pulses for one cycle, in the first cycle `busy` is low, and only when rbits is non-zero.
- R6: `sclk` rests at the clock-polarity level. With clock phase 0, data is sampled on the first edge of each bit. With clock phase 1, data is sampled on the second edge. `mosi_o` changes only at bit boundaries.
- R7: While busy, `cs_o` lines whose pattern bit is 1 are driven active and the other lines inactive. Active is low when chip-select polarity is 0 and high when it is 1. While idle, every line is inactive.
- R8: Every command presented while `busy` is high is ignored, and the configuration in use stays unchanged.
- R9: With the offline flag set, a data push is ignored: `busy` stays low and `sclk` and `cs_o` stay at their idle levels.
- R10: In half-duplex mode, receive bits are taken from `mosi_i`, `miso` is ignored, and `mosi_oe` is low during receive bits. In full-duplex mode, receive bits come from `miso`, `mosi_i` is ignored, and `mosi_oe` stays high.
- R11: A divider written as 0 acts as 1. A bit count written above 32 acts as 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_sel | input | 2 | Command code |
| cmd_data | input | DATA_W | Command payload |
| busy | output | 1 | Transfer in progress; commands ignored |
| sclk | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for the data-out driver |
| mosi_i | input | 1 | Data line read back (half-duplex receive) |
| miso | input | 1 | Serial data in (full-duplex receive) |
| cs_o | output | NCS | Chip-select lines |
| rd_data | output | DATA_W | Right-aligned received bits |
| rd_valid | output | 1 | One-cycle strobe when rd_data is updated |

## Verification
The assertions assume that the host changes the mode flags, dividers and shape only through the command port. They also assume that `rst_n` is held low for at least one clock edge before use, so that the configuration registers are always at legal values (non-zero dividers and counts no larger than 32). The stimulus issues commands only between transfers, except for deliberate attempts while `busy` is high, and random bit counts are drawn from 0 to 32. Out-of-range counts and zero dividers are presented only in directed cases, to exercise the saturation and clamping. The bench acts as the SPI target: it changes its receive line only after the sampling edge it expects for the active clock phase, so sampling on the wrong edge shows up as wrong received data.

// File: rtl/spi_ssm_pkg.sv
`timescale 1ns/1ps
package spi_ssm_pkg;

    // Mode flags, packed so that bit 0 is offline and bit 5 is half-duplex
    typedef struct packed {
        logic half_duplex;
        logic lsb_first;
        logic cpha;
        logic cpol;
        logic cs_pol;
        logic offline;
    } spi_flags_t;

    typedef enum logic [1:0] {
        SEL_FLAGS = 2'd0,
        SEL_DIV   = 2'd1,
        SEL_SHAPE = 2'd2,
        SEL_DATA  = 2'd3
    } spi_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_BITS  = 2'd2,
        ST_HOLD  = 2'd3
    } spi_state_e;

endpackage

// File: rtl/spi_ssm_cfg.sv
`timescale 1ns/1ps
module spi_ssm_cfg
    import spi_ssm_pkg::*;
#(
    parameter int NCS      = 4,
    parameter int DIV_W    = 8,
    parameter int DATA_W   = 32,
    parameter int LEN_W    = 6,
    parameter int RST_WDIV = 24,
    parameter int RST_RDIV = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_sel,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              busy,
    output spi_flags_t        flags_o,
    output logic [DIV_W-1:0]  wdiv_o,
    output logic [DIV_W-1:0]  rdiv_o,
    output logic [NCS-1:0]    cs_sel_o,
    output logic [LEN_W-1:0]  wlen_o,
    output logic [LEN_W-1:0]  rlen_o,
    output logic              start_o
);

    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DATA_W);

    typedef struct packed {
        spi_flags_t       flags;
        logic [DIV_W-1:0] wdiv;
        logic [DIV_W-1:0] rdiv;
        logic [NCS-1:0]   cs;
        logic [LEN_W-1:0] wlen;
        logic [LEN_W-1:0] rlen;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic             accept;
    logic [DIV_W-1:0] wdiv_in, rdiv_in;
    logic [LEN_W-1:0] wlen_in, rlen_in;
    logic             unused_cmd;

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] v);
        return (v == '0) ? DIV_W'(1) : v;
    endfunction

    function automatic logic [LEN_W-1:0] sat_len(input logic [LEN_W-1:0] v);
        return (v > LEN_MAX) ? LEN_MAX : v;
    endfunction

    assign accept     = cmd_valid && !busy;
    assign wdiv_in    = cmd_data[0 +: DIV_W];
    assign rdiv_in    = cmd_data[16 +: DIV_W];
    assign wlen_in    = cmd_data[8 +: LEN_W];
    assign rlen_in    = cmd_data[16 +: LEN_W];
    assign unused_cmd = ^cmd_data;

    always_comb begin
        cfg_d = cfg_q;
        if (accept) begin
            case (spi_sel_e'(cmd_sel))
                SEL_FLAGS: cfg_d.flags = spi_flags_t'(cmd_data[5:0]);
                SEL_DIV: begin
                    cfg_d.wdiv = clamp_div(wdiv_in);
                    cfg_d.rdiv = clamp_div(rdiv_in);
                end
                SEL_SHAPE: begin
                    cfg_d.cs   = cmd_data[NCS-1:0];
                    cfg_d.wlen = sat_len(wlen_in);
                    cfg_d.rlen = sat_len(rlen_in);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            cfg_q.wdiv <= DIV_W'(RST_WDIV);
            cfg_q.rdiv <= DIV_W'(RST_RDIV);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign start_o  = accept && (spi_sel_e'(cmd_sel) == SEL_DATA) && !cfg_q.flags.offline;
    assign flags_o  = cfg_q.flags;
    assign wdiv_o   = cfg_q.wdiv;
    assign rdiv_o   = cfg_q.rdiv;
    assign cs_sel_o = cfg_q.cs;
    assign wlen_o   = cfg_q.wlen;
    assign rlen_o   = cfg_q.rlen;

endmodule

// File: rtl/spi_ssm_halfcnt.sv
`timescale 1ns/1ps
module spi_ssm_halfcnt #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = div - DIV_W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // last cycle of the current half-period
    assign tick = (cnt_q == '0);

endmodule

// File: rtl/spi_ssm_engine.sv
`timescale 1ns/1ps
module spi_ssm_engine
    import spi_ssm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 8,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    input  spi_flags_t        flags,
    input  logic [DIV_W-1:0]  wdiv,
    input  logic [DIV_W-1:0]  rdiv,
    input  logic [LEN_W-1:0]  wlen,
    input  logic [LEN_W-1:0]  rlen,
    input  logic              miso,
    input  logic              mosi_i,
    input  logic              tick,
    output logic              load,
    output logic [DIV_W-1:0]  ld_div,
    output logic              busy,
    output logic              sclk,
    output logic              mosi_o,
    output logic              mosi_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int CNT_W = LEN_W + 1;
    localparam int IDX_W = $clog2(DATA_W);

    typedef struct packed {
        spi_state_e        st;
        logic              half;
        logic [CNT_W-1:0]  bitc;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] rd_data;
        logic              rd_valid;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [CNT_W-1:0] wlen_x, total, bitc_nx;
    logic             in_wr, nx_wr, rx_bit;
    logic [IDX_W-1:0] ridx;
    logic             unused_flags;

    assign wlen_x       = CNT_W'(wlen);
    assign total        = wlen_x + CNT_W'(rlen);
    assign bitc_nx      = eng_q.bitc + CNT_W'(1);
    assign in_wr        = eng_q.bitc < wlen_x;
    assign nx_wr        = bitc_nx < wlen_x;
    assign ridx         = IDX_W'(eng_q.bitc - wlen_x);
    assign rx_bit       = flags.half_duplex ? mosi_i : miso;
    assign unused_flags = flags.offline ^ flags.cs_pol;

    always_comb begin
        eng_d          = eng_q;
        eng_d.rd_valid = 1'b0;
        load           = 1'b0;
        ld_div         = wdiv;
        case (eng_q.st)
            ST_IDLE: begin
                if (start) begin
                    eng_d.st = ST_SETUP;
                    eng_d.sh = data;
                    eng_d.rx = '0;
                    load     = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    load = 1'b1;
                    if (total == '0) begin
                        eng_d.st = ST_HOLD;
                    end else begin
                        eng_d.st   = ST_BITS;
                        eng_d.half = 1'b0;
                        eng_d.bitc = '0;
                        ld_div     = (wlen_x != '0) ? wdiv : rdiv;
                    end
                end
            end
            ST_BITS: begin
                if (tick) begin
                    load = 1'b1;
                    if (!eng_q.half) begin
                        // sampling edge: middle of the bit
                        eng_d.half = 1'b1;
                        ld_div     = in_wr ? wdiv : rdiv;
                        if (!in_wr) begin
                            if (flags.lsb_first) eng_d.rx[ridx] = rx_bit;
                            else                 eng_d.rx = {eng_q.rx[DATA_W-2:0], rx_bit};
                        end
                    end else begin
                        eng_d.half = 1'b0;
                        eng_d.bitc = bitc_nx;
                        eng_d.sh   = flags.lsb_first ? (eng_q.sh >> 1) : (eng_q.sh << 1);
                        if (bitc_nx == total) begin
                            eng_d.st = ST_HOLD;
                        end else begin
                            ld_div = nx_wr ? wdiv : rdiv;
                        end
                    end
                end
            end
            default: begin
                if (tick) begin
                    eng_d.st       = ST_IDLE;
                    eng_d.rd_data  = eng_q.rx;
                    eng_d.rd_valid = (rlen != '0);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign busy     = (eng_q.st != ST_IDLE);
    assign sclk     = (eng_q.st == ST_BITS) ? (flags.cpol ^ flags.cpha ^ eng_q.half) : flags.cpol;
    assign mosi_o   = (eng_q.st == ST_BITS && in_wr)
                    ? (flags.lsb_first ? eng_q.sh[0] : eng_q.sh[DATA_W-1]) : 1'b0;
    assign mosi_oe  = !(flags.half_duplex && eng_q.st == ST_BITS && !in_wr);
    assign rd_data  = eng_q.rd_data;
    assign rd_valid = eng_q.rd_valid;

endmodule

// File: rtl/spi_split_master.sv
`timescale 1ns/1ps
module spi_split_master
    import spi_ssm_pkg::*;
#(
    parameter int NCS      = 4,
    parameter int DIV_W    = 8,
    parameter int DATA_W   = 32,
    parameter int RST_WDIV = 24,
    parameter int RST_RDIV = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_sel,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              busy,
    output logic              sclk,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              mosi_i,
    input  logic              miso,
    output logic [NCS-1:0]    cs_o,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int LEN_W = $clog2(DATA_W + 1);

    spi_flags_t       cfg_flags;
    logic [DIV_W-1:0] cfg_wdiv, cfg_rdiv, ld_div;
    logic [NCS-1:0]   cfg_cs;
    logic [LEN_W-1:0] cfg_wlen, cfg_rlen;
    logic             start, load, tick;

    spi_ssm_cfg #(
        .NCS(NCS), .DIV_W(DIV_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
        .RST_WDIV(RST_WDIV), .RST_RDIV(RST_RDIV)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
        .cmd_data(cmd_data), .busy(busy), .flags_o(cfg_flags),
        .wdiv_o(cfg_wdiv), .rdiv_o(cfg_rdiv), .cs_sel_o(cfg_cs),
        .wlen_o(cfg_wlen), .rlen_o(cfg_rlen), .start_o(start)
    );

    spi_ssm_halfcnt #(.DIV_W(DIV_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .div(ld_div), .tick(tick)
    );

    spi_ssm_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .data(cmd_data),
        .flags(cfg_flags), .wdiv(cfg_wdiv), .rdiv(cfg_rdiv),
        .wlen(cfg_wlen), .rlen(cfg_rlen), .miso(miso), .mosi_i(mosi_i),
        .tick(tick), .load(load), .ld_div(ld_div), .busy(busy), .sclk(sclk),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // one driver per chip-select line
    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_o[i] = busy ? (cfg_cs[i] ~^ cfg_flags.cs_pol) : ~cfg_flags.cs_pol;
    end

endmodule

// File: rtl/spi_split_master_chk.sv
`timescale 1ns/1ps
module spi_split_master_chk
    import spi_ssm_pkg::*;
#(
    parameter int NCS    = 4,
    parameter int DIV_W  = 8,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             busy,
    input logic             sclk,
    input logic             mosi_oe,
    input logic             rd_valid,
    input logic [NCS-1:0]   cs_o,
    input spi_flags_t       flags,
    input logic [DIV_W-1:0] wdiv,
    input logic [DIV_W-1:0] rdiv,
    input logic [LEN_W-1:0] wlen,
    input logic [LEN_W-1:0] rlen
);

    logic unused_chk;
    assign unused_chk = flags.cpha ^ flags.lsb_first;

    AST_IDLE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_o == {NCS{~flags.cs_pol}}); // R7
    AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk == flags.cpol); // R6
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cmd_valid |=> $stable(flags) && $stable(wdiv) && $stable(rdiv)
                              && $stable(wlen) && $stable(rlen)); // R8
    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R5
    AST_RDV_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy && $past(busy)); // R5
    AST_OFFLINE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && flags.offline |=> !busy); // R9
    AST_OE_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        !mosi_oe |-> busy && flags.half_duplex); // R10
    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wdiv != '0 && rdiv != '0); // R11
    AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wlen <= LEN_W'(DATA_W) && rlen <= LEN_W'(DATA_W)); // R11

endmodule

bind spi_split_master spi_split_master_chk #(
    .NCS(NCS), .DIV_W(DIV_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .sclk(sclk),
    .mosi_oe(mosi_oe), .rd_valid(rd_valid), .cs_o(cs_o), .flags(cfg_flags),
    .wdiv(cfg_wdiv), .rdiv(cfg_rdiv), .wlen(cfg_wlen), .rlen(cfg_rlen)
);

// File: tb/tb_spi_split_master.sv
`timescale 1ns/1ps
module tb_spi_split_master;

    localparam int NCS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_sel = 2'd0;
    logic [31:0] cmd_data = 32'd0;
    logic        busy, sclk, mosi_o, mosi_oe, rd_valid;
    logic        mosi_i = 1'b0, miso = 1'b0;
    logic [NCS-1:0] cs_o;
    logic [31:0] rd_data;

    spi_split_master dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
        .cmd_data(cmd_data), .busy(busy), .sclk(sclk), .mosi_o(mosi_o),
        .mosi_oe(mosi_oe), .mosi_i(mosi_i), .miso(miso), .cs_o(cs_o),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    int checks = 0;
    int fails  = 0;

    // bench copy of the configuration, per the requirements
    logic [5:0]     m_flags = 6'd0;
    logic [NCS-1:0] m_cs = '0;
    int m_wdiv = 24, m_rdiv = 64, m_wlen = 0, m_rlen = 0;

    // target model state
    int          edge_k = 0, busy_cnt = 0, cs_err = 0, oe_err = 0;
    logic        prev_sclk = 1'b0;
    logic [31:0] cap_w = 32'd0, rpat = 32'd0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NCS-1:0] exp_cs(input bit active);
        if (!active) return {NCS{~m_flags[1]}};
        return m_flags[1] ? m_cs : ~m_cs;
    endfunction

    // SPI target: samples on the edge the clock phase selects, changes its data after it
    always @(negedge clk) begin
        int  j;
        logic b;
        if (busy) begin
            busy_cnt++;
            if (cs_o !== exp_cs(1'b1)) cs_err++;
            if (sclk !== prev_sclk) begin
                if (m_flags[3] ? (sclk == m_flags[2]) : (sclk != m_flags[2])) begin
                    if (edge_k < m_wlen) begin
                        if (edge_k < 32) cap_w[edge_k] = mosi_o;
                        if (!mosi_oe) oe_err++;
                    end else if (mosi_oe !== !m_flags[5]) begin
                        oe_err++;
                    end
                    edge_k++;
                end
            end
        end
        prev_sclk = sclk;
        j = (edge_k > m_wlen) ? edge_k - m_wlen : 0;
        b = 1'b0;
        if (j < m_rlen) b = m_flags[4] ? rpat[j] : rpat[m_rlen-1-j];
        if (m_flags[5]) begin
            mosi_i = b;
            miso   = 1'($urandom);
        end else begin
            miso   = b;
            mosi_i = 1'($urandom);
        end
    end

    task automatic send(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_sel   = sel;
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic set_flags(input logic [5:0] f);
        send(2'd0, {26'd0, f});
        m_flags = f;
    endtask

    task automatic set_div(input int w, input int r);
        send(2'd1, {8'd0, 8'(r), 8'd0, 8'(w)});
        m_wdiv = (w == 0) ? 1 : w;
        m_rdiv = (r == 0) ? 1 : r;
    endtask

    task automatic set_shape(input logic [NCS-1:0] cs, input int wl, input int rl);
        send(2'd2, {10'd0, 6'(rl), 2'd0, 6'(wl), 4'd0, cs});
        m_cs   = cs;
        m_wlen = (wl > 32) ? 32 : wl;
        m_rlen = (rl > 32) ? 32 : rl;
    endtask

    task automatic run_xfer(input logic [31:0] word, input logic [31:0] pat, input bit poke);
        logic [31:0] exp_w, exp_r;
        int n, exp_busy;
        rpat = pat; edge_k = 0; busy_cnt = 0; cap_w = 32'd0; cs_err = 0; oe_err = 0;
        send(2'd3, word);
        if (poke) begin
            repeat (2) @(negedge clk);
            send(2'd2, {10'd0, 6'd5, 2'd0, 6'd20, 4'd0, 4'h2});
            send(2'd0, {26'd0, 6'h0A});
        end
        n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        exp_busy = 2*m_wdiv + 2*(m_wlen*m_wdiv + m_rlen*m_rdiv);
        chk(busy_cnt == exp_busy, "R3 busy length", 32'(busy_cnt), 32'(exp_busy));
        chk(edge_k == m_wlen + m_rlen, "R6 sampling edge count", 32'(edge_k), 32'(m_wlen + m_rlen));
        exp_w = 32'd0;
        for (int k = 0; k < m_wlen; k++) exp_w[k] = m_flags[4] ? word[k] : word[31-k];
        chk(cap_w == exp_w, "R4 sent bits", cap_w, exp_w);
        chk(cs_err == 0, "R7 chip select while busy", 32'(cs_err), 32'd0);
        chk(oe_err == 0, "R10 data driver enable", 32'(oe_err), 32'd0);
        chk(rd_valid == (m_rlen != 0), "R5 rd_valid strobe", 32'(rd_valid), 32'(m_rlen != 0));
        if (m_rlen != 0) begin
            exp_r = 32'd0;
            for (int k = 0; k < m_rlen; k++) exp_r[k] = pat[k];
            chk(rd_data == exp_r, "R5 received data", rd_data, exp_r);
        end
        chk(sclk == m_flags[2] && cs_o == exp_cs(1'b0), "R6 R7 idle levels after transfer",
            {27'd0, sclk, cs_o}, {27'd0, m_flags[2], exp_cs(1'b0)});
    endtask

    initial begin
        #750000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit ok;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk(!busy && !sclk && !rd_valid, "R2 reset busy/sclk/rd_valid",
            {29'd0, busy, sclk, rd_valid}, 32'd0);
        chk(cs_o == 4'hF && mosi_oe, "R2 reset cs_o/mosi_oe", {27'd0, mosi_oe, cs_o}, 32'h1F);

        // R2 R1: default dividers 24/64, typical 16/8 shape
        set_shape(4'b0101, 16, 8);
        run_xfer(32'hA5C3_1234, 32'h0000_005A, 1'b0);

        // R1 R3: other shapes, write divider differs from read divider
        set_div(3, 5);
        set_shape(4'b0001, 24, 8);
        run_xfer(32'h1357_9BDF, 32'h0000_00C6, 1'b0);
        set_shape(4'b1000, 0, 16);
        run_xfer(32'hFFFF_FFFF, 32'h0000_B2E1, 1'b0);
        set_shape(4'b0010, 0, 0);
        run_xfer(32'h0, 32'h0, 1'b0);

        // R6 R4 R5: every clock mode in both bit orders
        for (int m = 0; m < 8; m++) begin
            set_flags({1'b0, 1'(m >> 2), 1'(m >> 1), 1'(m), 2'b00});
            set_div(2, 4);
            set_shape(4'b0110, 12, 10);
            run_xfer(32'h9E37_79B9 ^ 32'(m), 32'h0000_02A5 + 32'(m), 1'b0);
        end

        // R10 half-duplex turnaround, R7 active-high chip select
        set_flags(6'b100000);
        set_div(1, 3);
        set_shape(4'b1001, 8, 8);
        run_xfer(32'hC300_0000, 32'h0000_003C, 1'b0);
        set_flags(6'b110010);
        run_xfer(32'h0000_00A7, 32'h0000_0081, 1'b0);

        // R8 commands during busy are ignored
        set_flags(6'd0);
        set_div(3, 2);
        set_shape(4'b0001, 8, 0);
        run_xfer(32'hF0A5_0000, 32'h0, 1'b1);
        run_xfer(32'h0F5A_0000, 32'h0, 1'b0);

        // R9 offline ignores a data push
        set_flags(6'b000001);
        send(2'd3, 32'hDEAD_BEEF);
        ok = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (busy || sclk || cs_o != 4'hF) ok = 1'b0;
        end
        chk(ok, "R9 offline stays parked", {27'd0, busy, sclk, cs_o}, 32'h0F);
        set_flags(6'd0);

        // R11 zero dividers act as 1, long counts saturate at 32
        set_div(0, 0);
        set_shape(4'b1111, 40, 45);
        run_xfer(32'h8000_0001, 32'h8765_4321, 1'b0);

        // random mix
        for (int i = 0; i < 30; i++) begin
            set_flags(6'($urandom) & 6'h3E);
            set_div(1 + int'($urandom % 6), 1 + int'($urandom % 6));
            set_shape(4'($urandom), int'($urandom % 33), int'($urandom % 33));
            run_xfer($urandom, $urandom, 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule